// File: doc/BRIEF.md
# Sector Protection Command Sequencer

This block decodes bus write cycles that arrive at a flash-style device and keeps the per-sector protection state that those cycles change. It holds three kinds of state: a nonvolatile protection bit for each sector, a volatile protection bit for each sector, and one global freeze flag. While the freeze flag is set, the nonvolatile bits cannot change. The nonvolatile bits are held in plain registers.

The block stays in normal mode until it sees two fixed unlock writes followed by a mode-select write. That sequence opens one of three protection command sets. In each set, two-write commands set bits, clear bits or erase bits. A read strobe returns the bit that the open set exposes for the addressed sector, or the freeze flag. The set stays open until the two-write exit sequence arrives.

Top module: `sprot_seq`

## Requirements
- R1: The block enters a protection set after three writes: data AA with address bits [11:0] = AAA, then data 55 with bits [11:0] = 555, then a mode byte with bits [11:0] = AAA. Mode byte C0 opens the nonvolatile set, 50 opens the freeze set and E0 opens the volatile set. Address bits above bit 11 are ignored in these writes.
- R2: In any set, data 90 followed by data 00, each at any address, returns the block to normal mode. A status read in normal mode returns 00.
- R3: In the nonvolatile set, A0 followed by 00 at a sector address sets that sector's nonvolatile bit.
- R4: In the nonvolatile set, 80 followed by 30 at address 0 (every address bit zero) clears all nonvolatile bits.
- R5: In the volatile set, A0 followed by 00 at a sector address sets that sector's volatile bit, and A0 followed by 01 clears it.
- R6: In the freeze set, A0 followed by 00 sets the freeze flag. Only reset clears the flag.
- R7: While the freeze flag is set, nonvolatile set and erase commands leave every nonvolatile bit unchanged.
- R8: Data bit 0 of a read holds the addressed bit of the open set (nonvolatile, volatile, or the freeze flag in the freeze set). Bits 7:1 read as 0. rvalid_o and rdata_o are valid in the clock cycle after rd_i.
- R9: Address bits [ADDR_W-1:16] select the sector. Bits [15:0] play no part in selecting it.
- R10: A write that does not match the expected next cycle sends the decoder back to normal mode if entry is not complete. If a set is already open, it sends the decoder back to that set's top level, with no bit changed.
- R11: Reset clears every bit and returns the block to normal mode. Nonvolatile bits and the freeze flag keep their values through a set exit and a later re-entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle status read strobe |
| addr_i | input | ADDR_W | Address for writes and reads |
| wdata_i | input | 8 | Write data byte |
| rvalid_o | output | 1 | Read data valid, one clock after rd_i |
| rdata_o | output | 8 | Status byte, protection bit on bit 0 |

## Verification
The assertions assume that wr_i and rd_i are never high in the same cycle and that each strobe stands for one transfer per high cycle. The bench drives each strobe for exactly one cycle on the falling clock edge and never overlaps a read with a write. The bench sweeps every sector of a 16-sector configuration and uses nonzero low address bits, so that any dependence on bits [15:0] would show up. It also places deliberately broken sequences between valid ones, so that the property checks see commands both accepted and rejected.

// File: rtl/sprot_pkg.sv
`timescale 1ns/1ps
package sprot_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_U1, ST_U2,
    ST_NV_TOP, ST_NV_A0, ST_NV_80, ST_NV_90,
    ST_FZ_TOP, ST_FZ_A0, ST_FZ_90,
    ST_VL_TOP, ST_VL_A0, ST_VL_90
  } seq_state_e;

  typedef enum logic [1:0] {MODE_NORM, MODE_NV, MODE_FZ, MODE_VL} prot_mode_e;

  typedef struct packed {
    logic nv_set;
    logic nv_erase;
    logic vl_set;
    logic vl_clr;
    logic lock_set;
  } prot_cmd_t;

  localparam logic [11:0] UNLOCK_A = 12'hAAA;
  localparam logic [11:0] UNLOCK_B = 12'h555;
endpackage

// File: rtl/sprot_decoder.sv
`timescale 1ns/1ps
module sprot_decoder
  import sprot_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output prot_cmd_t         cmd_o,
  output prot_mode_e        mode_o
);
  seq_state_e state_q, state_d;
  logic is_a, is_b, is_zero;

  assign is_a    = addr_i[11:0] == UNLOCK_A;
  assign is_b    = addr_i[11:0] == UNLOCK_B;
  assign is_zero = addr_i == '0;

  always_comb begin
    state_d = state_q;
    cmd_o   = '0;
    if (wr_i) begin
      unique case (state_q)
        ST_IDLE: state_d = (is_a && wdata_i == 8'hAA) ? ST_U1 : ST_IDLE;
        ST_U1:   state_d = (is_b && wdata_i == 8'h55) ? ST_U2 : ST_IDLE;
        ST_U2: begin
          state_d = ST_IDLE;
          if (is_a) begin
            case (wdata_i)
              8'hC0:   state_d = ST_NV_TOP;
              8'h50:   state_d = ST_FZ_TOP;
              8'hE0:   state_d = ST_VL_TOP;
              default: state_d = ST_IDLE;
            endcase
          end
        end
        ST_NV_TOP: begin
          case (wdata_i)
            8'hA0:   state_d = ST_NV_A0;
            8'h80:   state_d = ST_NV_80;
            8'h90:   state_d = ST_NV_90;
            default: state_d = ST_NV_TOP;
          endcase
        end
        ST_NV_A0: begin
          cmd_o.nv_set = wdata_i == 8'h00;
          state_d      = ST_NV_TOP;
        end
        ST_NV_80: begin
          cmd_o.nv_erase = (wdata_i == 8'h30) && is_zero;
          state_d        = ST_NV_TOP;
        end
        ST_NV_90: state_d = (wdata_i == 8'h00) ? ST_IDLE : ST_NV_TOP;
        ST_FZ_TOP: begin
          case (wdata_i)
            8'hA0:   state_d = ST_FZ_A0;
            8'h90:   state_d = ST_FZ_90;
            default: state_d = ST_FZ_TOP;
          endcase
        end
        ST_FZ_A0: begin
          cmd_o.lock_set = wdata_i == 8'h00;
          state_d        = ST_FZ_TOP;
        end
        ST_FZ_90: state_d = (wdata_i == 8'h00) ? ST_IDLE : ST_FZ_TOP;
        ST_VL_TOP: begin
          case (wdata_i)
            8'hA0:   state_d = ST_VL_A0;
            8'h90:   state_d = ST_VL_90;
            default: state_d = ST_VL_TOP;
          endcase
        end
        ST_VL_A0: begin
          cmd_o.vl_set = wdata_i == 8'h00;
          cmd_o.vl_clr = wdata_i == 8'h01;
          state_d      = ST_VL_TOP;
        end
        ST_VL_90: state_d = (wdata_i == 8'h00) ? ST_IDLE : ST_VL_TOP;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    unique case (state_q)
      ST_NV_TOP, ST_NV_A0, ST_NV_80, ST_NV_90: mode_o = MODE_NV;
      ST_FZ_TOP, ST_FZ_A0, ST_FZ_90:           mode_o = MODE_FZ;
      ST_VL_TOP, ST_VL_A0, ST_VL_90:           mode_o = MODE_VL;
      default:                                 mode_o = MODE_NORM;
    endcase
  end

  assert_entry_nv_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_U2 && wr_i && is_a && wdata_i == 8'hC0) |=> mode_o == MODE_NV);

  assert_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_NORM && $past(wr_i) && $past(wdata_i) == 8'h90 && wr_i && wdata_i == 8'h00
     && state_q inside {ST_NV_90, ST_FZ_90, ST_VL_90}) |=> mode_o == MODE_NORM);

  assert_set_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != MODE_NORM && !(state_q inside {ST_NV_90, ST_FZ_90, ST_VL_90}))
      |=> mode_o == $past(mode_o));
endmodule

// File: rtl/sprot_bits.sv
`timescale 1ns/1ps
module sprot_bits
  import sprot_pkg::*;
#(
  parameter int NSECT  = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  prot_cmd_t         cmd_i,
  input  logic [SECT_W-1:0] sect_i,
  output logic [NSECT-1:0]  nv_o,
  output logic [NSECT-1:0]  vl_o,
  output logic              lock_o
);
  logic [NSECT-1:0] nv_q, vl_q;
  logic             lock_q;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic hit;
    assign hit = sect_i == SECT_W'(s);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nv_q[s] <= 1'b0;
      end else if (!lock_q) begin
        if (cmd_i.nv_erase)          nv_q[s] <= 1'b0;
        else if (cmd_i.nv_set && hit) nv_q[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 vl_q[s] <= 1'b0;
      else if (cmd_i.vl_set && hit) vl_q[s] <= 1'b1;
      else if (cmd_i.vl_clr && hit) vl_q[s] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             lock_q <= 1'b0;
    else if (cmd_i.lock_set) lock_q <= 1'b1;
  end

  assign nv_o   = nv_q;
  assign vl_o   = vl_q;
  assign lock_o = lock_q;

  assert_cmd_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_i));

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);

  assert_nv_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(nv_q));

  assert_vl_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i.vl_set |=> vl_q[$past(sect_i)]);
endmodule

// File: rtl/sprot_seq.sv
`timescale 1ns/1ps
module sprot_seq
  import sprot_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SECT_LSB = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic              rvalid_o,
  output logic [7:0]        rdata_o
);
  localparam int SECT_W = ADDR_W - SECT_LSB;
  localparam int NSECT  = 1 << SECT_W;

  prot_cmd_t         cmd;
  prot_mode_e        mode;
  logic [SECT_W-1:0] sect;
  logic [NSECT-1:0]  nv, vl;
  logic              lock, sel_bit, rvalid_q, rbit_q;

  assign sect = addr_i[ADDR_W-1:SECT_LSB];

  sprot_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cmd_o(cmd), .mode_o(mode)
  );

  sprot_bits #(.NSECT(NSECT), .SECT_W(SECT_W)) u_bits (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd), .sect_i(sect),
    .nv_o(nv), .vl_o(vl), .lock_o(lock)
  );

  always_comb begin
    unique case (mode)
      MODE_NV: sel_bit = nv[sect];
      MODE_VL: sel_bit = vl[sect];
      MODE_FZ: sel_bit = lock;
      default: sel_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rbit_q   <= 1'b0;
    end else begin
      rvalid_q <= rd_i;
      rbit_q   <= rd_i & sel_bit;
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = {7'b0, rbit_q};

  assert_rd_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  assert_norm_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode == MODE_NORM) |=> rdata_o == 8'h00);

  assert_fz_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode == MODE_FZ && lock) |=> rdata_o == 8'h01);
endmodule

// File: tb/sprot_seq_tb.sv
`timescale 1ns/1ps
module sprot_seq_tb;
  localparam int ADDR_W = 20;
  localparam int NS     = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic rvalid;
  logic [7:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit nv_m[NS], vl_m[NS];

  always #2.5 clk = ~clk;

  sprot_seq #(.ADDR_W(ADDR_W), .SECT_LSB(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata)
  );

  function automatic logic [ADDR_W-1:0] sa(input int s, input logic [15:0] lo);
    return {4'(s), lo};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_c(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [7:0] exp);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    chk({req, " rvalid"}, {7'b0, rvalid}, 8'h01);
    chk(req, rdata, exp);
  endtask

  task automatic enter(input logic [7:0] m);
    wr_c(20'h5_0AAA, 8'hAA);
    wr_c(20'h3_0555, 8'h55);
    wr_c(20'h0_0AAA, m);
  endtask

  task automatic leave();
    wr_c(20'h7_1234, 8'h90);
    wr_c(20'h2_0000, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 reset rvalid", {7'b0, rvalid}, 8'h00);
    rd_chk("R2 normal read", sa(3, 16'h0), 8'h00);

    // R1 / R11: enter nonvolatile set, all bits clear after reset
    enter(8'hC0);
    for (int s = 0; s < NS; s++) rd_chk("R11 nv reset", sa(s, 16'h0), 8'h00);

    // R3 / R9: set every third sector with nonzero low address bits
    for (int s = 0; s < NS; s += 3) begin
      wr_c(20'h0_0AAA, 8'hA0);
      wr_c(sa(s, 16'hBEEF), 8'h00);
      nv_m[s] = 1'b1;
    end
    for (int s = 0; s < NS; s++)
      rd_chk("R3 R9 nv sweep", sa(s, 16'(s * 16'h1111)), {7'b0, nv_m[s]});

    // R10: broken command returns to top, stray 00 does nothing
    wr_c(20'h0_0000, 8'hA0);
    wr_c(sa(1, 16'h0), 8'h55);
    wr_c(sa(1, 16'h0), 8'h00);
    rd_chk("R10 nv mismatch", sa(1, 16'h0), 8'h00);

    // R10: erase at nonzero address rejected; R4: erase at address 0
    wr_c(20'h0_0000, 8'h80);
    wr_c(20'h0_0010, 8'h30);
    rd_chk("R10 erase wrong addr", sa(3, 16'h0), 8'h01);
    wr_c(20'h0_0000, 8'h80);
    wr_c(20'h0_0000, 8'h30);
    for (int s = 0; s < NS; s++) begin
      nv_m[s] = 1'b0;
      rd_chk("R4 erase all", sa(s, 16'h0), 8'h00);
    end
    wr_c(20'h0_0000, 8'hA0); wr_c(sa(2, 16'h0), 8'h00); nv_m[2] = 1'b1;
    wr_c(20'h0_0000, 8'hA0); wr_c(sa(5, 16'h0), 8'h00); nv_m[5] = 1'b1;

    // R2: exit, reads return 0
    leave();
    rd_chk("R2 exit normal", sa(2, 16'h0), 8'h00);

    // R10: broken entry stays in normal mode
    wr_c(20'h0_0AAA, 8'hAA);
    wr_c(20'h0_0554, 8'h55);
    wr_c(20'h0_0AAA, 8'hC0);
    rd_chk("R10 bad entry", sa(2, 16'h0), 8'h00);

    // R11: nonvolatile bits survive exit and re-entry
    enter(8'hC0);
    rd_chk("R11 nv persist", sa(2, 16'h0), 8'h01);
    rd_chk("R11 nv persist", sa(5, 16'h0), 8'h01);
    leave();

    // R5: volatile set, even sectors set, then clear sector 4
    enter(8'hE0);
    rd_chk("R5 vl shows vl not nv", sa(2, 16'h0), 8'h00);
    for (int s = 0; s < NS; s += 2) begin
      wr_c(20'h0_0000, 8'hA0); wr_c(sa(s, 16'h7777), 8'h00); vl_m[s] = 1'b1;
    end
    wr_c(20'h0_0000, 8'hA0); wr_c(sa(4, 16'h0), 8'h01); vl_m[4] = 1'b0;
    wr_c(20'h0_0000, 8'hA0); wr_c(sa(9, 16'h0), 8'h01); vl_m[9] = 1'b0;
    for (int s = 0; s < NS; s++)
      rd_chk("R5 vl sweep", sa(s, 16'h0), {7'b0, vl_m[s]});
    leave();

    // R6: freeze set
    enter(8'h50);
    rd_chk("R6 lock clear", 20'h0, 8'h00);
    wr_c(20'h0_0000, 8'hA0);
    wr_c(20'h0_0000, 8'h00);
    rd_chk("R8 R6 lock set", sa(9, 16'h0), 8'h01);
    leave();

    // R7: nonvolatile frozen
    enter(8'hC0);
    wr_c(20'h0_0000, 8'hA0); wr_c(sa(7, 16'h0), 8'h00);
    rd_chk("R7 set frozen", sa(7, 16'h0), 8'h00);
    wr_c(20'h0_0000, 8'h80); wr_c(20'h0_0000, 8'h30);
    for (int s = 0; s < NS; s++)
      rd_chk("R7 erase frozen", sa(s, 16'h0), {7'b0, nv_m[s]});
    leave();
    enter(8'h50);
    rd_chk("R6 lock sticky", 20'h0, 8'h01);
    leave();

    // R11: reset clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    enter(8'hC0);
    rd_chk("R11 reset nv", sa(2, 16'h0), 8'h00);
    leave();
    enter(8'hE0);
    rd_chk("R11 reset vl", sa(0, 16'h0), 8'h00);
    leave();
    enter(8'h50);
    rd_chk("R11 reset lock", 20'h0, 8'h00);
    leave();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule